// File: doc/BRIEF.md
# J1850 Byte Buffer and Flag Path

This block is the byte-level layer between a processor data register and a J1850 bit engine. Toward the processor it offers one 8-bit data location: writing it fills a transmit holding byte, and reading it returns the most recent byte that came off the bus. Toward the bit engine it hands out transmit bits one per request, most significant bit first, and it assembles received bits into bytes.

On the transmit side a holding byte feeds a shift register. The empty flag rises only once the shift register has put out the first bit of a freshly moved byte. A held byte is discarded when the engine reports lost arbitration, a transmit error, a bad symbol, a framing error, a bus fault or a break. A held byte marked as an in-frame response is also discarded on a CRC error. If the shift register runs dry, the transmitter sends trailing one bits so the frame ends off a byte boundary. It then stops and reports an invalid symbol to the receive status path.

On the receive side each completed byte is copied into a receive holding byte. The copy raises either the receive-full flag or the in-frame-response flag, and it overwrites whatever the processor has not yet read.

Top module: `j1850_byte_path`

## Requirements
- R1: After reset `cpu_rdata` is 0, `tx_empty` is 1, and `rx_full`, `rx_ifr_full`, `tx_pending`, `tx_pend_ifr`, `tx_bit`, `tx_active`, `tx_byte_done`, `tx_underrun` and `inv_symbol` are all 0.
- R2: A `cpu_wr` stores `cpu_wdata` as the held byte. From the next cycle `tx_pending` is 1, `tx_empty` is 0, and `tx_pend_ifr` equals the `cpu_ifr` value sampled with the write. A write wins over a same-cycle move that would set `tx_empty`.
- R3: A write made while a byte is still held, before any bit of it has been requested, replaces that byte. Only the last written byte is transmitted.
- R4: A `bit_req` while idle with a byte held moves the byte into the shift register. In the next cycle `tx_bit` shows its bit 7, `tx_active` is 1, `tx_empty` is 1 and `tx_pending` is 0.
- R5: Each further `bit_req` presents the next lower bit on `tx_bit` in the following cycle. `tx_byte_done` is 1 for exactly the cycle in which bit 0 is presented.
- R6: A `bit_req` after bit 0 while a byte is held moves that byte in with no idle gap: `tx_active` stays 1 and its bit 7 follows at once.
- R7: A `bit_req` after bit 0 with nothing held is an underrun. `tx_bit` is 1 for that and the next request, and `tx_underrun` pulses with the first of them. The request after those two 1 bits returns the transmitter to idle with `tx_bit` 0 and pulses `inv_symbol` for one cycle.
- R8: Any of `ev_arb_lost`, `ev_tx_err`, `ev_sym_err`, `ev_frame_err`, `ev_bus_fault` or `ev_break` flushes the held byte and cancels transmission. Next cycle `tx_pending` is 0, `tx_empty` is 1, `tx_active` is 0 and `tx_bit` is 0. A same-cycle write or bit request is dropped.
- R9: `ev_crc_err` flushes in the same way as R8 only while the held byte is marked as an in-frame response. Otherwise it has no effect.
- R10: Received bits (`rx_bit_vld`, `rx_bit`) are assembled MSB first. The 8th bit copies the byte to `cpu_rdata` in the next cycle and sets `rx_ifr_full` if `rx_in_ifr` is 1 with that bit, otherwise `rx_full`. `rx_sync` restarts the bit count, and any bit given in the same cycle is ignored.
- R11: A completed byte overwrites `cpu_rdata` even if the previous byte was never read.
- R12: `cpu_rd` clears both `rx_full` and `rx_ifr_full` from the next cycle. A flag set in the same cycle as the read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Data register write strobe |
| cpu_wdata | input | 8 | Byte to transmit |
| cpu_ifr | input | 1 | Marks the written byte as in-frame response |
| cpu_rd | input | 1 | Data register read strobe, clears receive flags |
| cpu_rdata | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit holding byte may be written |
| rx_full | output | 1 | New received byte available |
| rx_ifr_full | output | 1 | New in-frame-response byte available |
| tx_pending | output | 1 | A byte is held awaiting transmission |
| tx_pend_ifr | output | 1 | The held byte is an in-frame response |
| bit_req | input | 1 | Bit engine asks for the next transmit bit |
| tx_bit | output | 1 | Transmit bit |
| tx_active | output | 1 | Transmitter is sending a byte or tail |
| tx_byte_done | output | 1 | Byte boundary strobe with the last data bit |
| tx_underrun | output | 1 | Pulse at the start of the underrun tail |
| inv_symbol | output | 1 | Pulse reporting an invalid symbol after the tail |
| rx_sync | input | 1 | Restart receive byte alignment |
| rx_bit_vld | input | 1 | Received bit valid |
| rx_bit | input | 1 | Received bit |
| rx_in_ifr | input | 1 | Current received byte belongs to an in-frame response |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_tx_err | input | 1 | Transmitter error |
| ev_sym_err | input | 1 | Invalid symbol received |
| ev_frame_err | input | 1 | Framing error |
| ev_bus_fault | input | 1 | Bus fault |
| ev_break | input | 1 | Break received |
| ev_crc_err | input | 1 | Received frame failed CRC |

## Verification
The bench drives rewrites before the first bit. A design that queued them would send the stale byte. It checks the exact cycle in which the empty flag rises, which catches a flag set on the write or on the move instead of after the first bit. Back-to-back bytes and an underrun tail show whether a design inserts an idle gap, sends the wrong number of trailing ones or forgets the invalid-symbol pulse. CRC errors with and without an in-frame-response byte held, unread received bytes, and reads colliding with byte completion expose flushes that are too broad, lost overwrites and clear-over-set priority errors.

// File: rtl/j1850_pkg.sv
package j1850_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_TAIL} tx_state_e;
endpackage

// File: rtl/j1850_tx_buf.sv
module j1850_tx_buf
  import j1850_pkg::*;
#(
  parameter int W         = 8,
  parameter int TAIL_BITS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         wr_ifr,
  input  logic         bit_req,
  input  logic         bus_evt,
  input  logic         crc_err,
  output logic         tdre,
  output logic         pending,
  output logic         pend_ifr,
  output logic         tx_bit,
  output logic         tx_active,
  output logic         byte_done,
  output logic         underrun,
  output logic         inv_sym
);
  localparam int BCW = (W > 2) ? $clog2(W) : 1;
  localparam int TCW = $clog2(TAIL_BITS + 1);

  tx_state_e    state;
  logic [W-1:0] hold_q;
  logic [W-1:0] shift_q;
  logic [BCW-1:0] bits_left;
  logic [TCW-1:0] tail_left;
  logic flush, do_load, byte_end;

  assign flush    = bus_evt | (crc_err & pending & pend_ifr);
  assign byte_end = (state == TX_SHIFT) && (bits_left == '0);
  assign do_load  = !flush && bit_req && pending && ((state == TX_IDLE) || byte_end);
  assign tx_active = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      hold_q    <= '0;
      shift_q   <= '0;
      bits_left <= '0;
      tail_left <= '0;
      pending   <= 1'b0;
      pend_ifr  <= 1'b0;
      tdre      <= 1'b1;
      tx_bit    <= 1'b0;
      byte_done <= 1'b0;
      underrun  <= 1'b0;
      inv_sym   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      underrun  <= 1'b0;
      inv_sym   <= 1'b0;
      if (flush) begin
        state   <= TX_IDLE;
        pending <= 1'b0;
        tdre    <= 1'b1;
        tx_bit  <= 1'b0;
      end else begin
        if (do_load) begin
          tx_bit    <= hold_q[W-1];
          shift_q   <= {hold_q[W-2:0], 1'b0};
          bits_left <= BCW'(W - 1);
          pending   <= 1'b0;
          tdre      <= 1'b1;
          state     <= TX_SHIFT;
        end else if (bit_req) begin
          case (state)
            TX_SHIFT: begin
              if (bits_left != '0) begin
                tx_bit    <= shift_q[W-1];
                shift_q   <= {shift_q[W-2:0], 1'b0};
                bits_left <= bits_left - 1'b1;
                byte_done <= (bits_left == BCW'(1));
              end else begin
                tx_bit    <= 1'b1;
                underrun  <= 1'b1;
                tail_left <= TCW'(TAIL_BITS - 1);
                state     <= TX_TAIL;
              end
            end
            TX_TAIL: begin
              if (tail_left != '0) begin
                tx_bit    <= 1'b1;
                tail_left <= tail_left - 1'b1;
              end else begin
                tx_bit  <= 1'b0;
                inv_sym <= 1'b1;
                state   <= TX_IDLE;
              end
            end
            default: ;
          endcase
        end
        if (wr) begin
          hold_q   <= wdata;
          pending  <= 1'b1;
          pend_ifr <= wr_ifr;
          tdre     <= 1'b0;
        end
      end
    end
  end

  assert_write_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && !flush) |=> (pending && !tdre));
  assert_flush_idle_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tdre && !pending && !tx_active && !tx_bit));
  assert_load_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (do_load && !wr) |=> (tdre && tx_active && !pending));
  assert_tail_one_R7: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (tx_bit && tx_active));
  assert_inv_idle_R7: assert property (@(posedge clk) disable iff (rst)
    inv_sym |-> (!tx_active && !tx_bit));
endmodule

// File: rtl/j1850_rx_buf.sv
module j1850_rx_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync,
  input  logic         bit_vld,
  input  logic         bit_in,
  input  logic         in_ifr,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         ifr_full
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;
  logic          byte_end;

  assign byte_end = !sync && bit_vld && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      rdata    <= '0;
      full     <= 1'b0;
      ifr_full <= 1'b0;
    end else begin
      if (sync) begin
        cnt_q <= '0;
      end else if (bit_vld) begin
        acc_q <= {acc_q[W-2:0], bit_in};
        if (byte_end) begin
          cnt_q <= '0;
          rdata <= {acc_q[W-2:0], bit_in};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (byte_end && !in_ifr) full <= 1'b1;
      else if (rd)             full <= 1'b0;
      if (byte_end && in_ifr)  ifr_full <= 1'b1;
      else if (rd)             ifr_full <= 1'b0;
    end
  end

  assert_read_clears_R12: assert property (@(posedge clk) disable iff (rst)
    (rd && !byte_end) |=> (!full && !ifr_full));
  assert_byte_flags_R10: assert property (@(posedge clk) disable iff (rst)
    byte_end |=> (full || ifr_full));
  assert_sync_nodata_R10: assert property (@(posedge clk) disable iff (rst)
    sync |=> $stable(rdata));
endmodule

// File: rtl/j1850_byte_path.sv
module j1850_byte_path #(
  parameter int W         = 8,
  parameter int TAIL_BITS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wdata,
  input  logic         cpu_ifr,
  input  logic         cpu_rd,
  output logic [W-1:0] cpu_rdata,
  output logic         tx_empty,
  output logic         rx_full,
  output logic         rx_ifr_full,
  output logic         tx_pending,
  output logic         tx_pend_ifr,
  input  logic         bit_req,
  output logic         tx_bit,
  output logic         tx_active,
  output logic         tx_byte_done,
  output logic         tx_underrun,
  output logic         inv_symbol,
  input  logic         rx_sync,
  input  logic         rx_bit_vld,
  input  logic         rx_bit,
  input  logic         rx_in_ifr,
  input  logic         ev_arb_lost,
  input  logic         ev_tx_err,
  input  logic         ev_sym_err,
  input  logic         ev_frame_err,
  input  logic         ev_bus_fault,
  input  logic         ev_break,
  input  logic         ev_crc_err
);
  logic bus_evt;
  assign bus_evt = |{ev_arb_lost, ev_tx_err, ev_sym_err, ev_frame_err, ev_bus_fault, ev_break};

  j1850_tx_buf #(.W(W), .TAIL_BITS(TAIL_BITS)) u_tx (
    .clk(clk), .rst(rst), .wr(cpu_wr), .wdata(cpu_wdata), .wr_ifr(cpu_ifr),
    .bit_req(bit_req), .bus_evt(bus_evt), .crc_err(ev_crc_err),
    .tdre(tx_empty), .pending(tx_pending), .pend_ifr(tx_pend_ifr),
    .tx_bit(tx_bit), .tx_active(tx_active), .byte_done(tx_byte_done),
    .underrun(tx_underrun), .inv_sym(inv_symbol)
  );

  j1850_rx_buf #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .sync(rx_sync), .bit_vld(rx_bit_vld), .bit_in(rx_bit),
    .in_ifr(rx_in_ifr), .rd(cpu_rd), .rdata(cpu_rdata), .full(rx_full),
    .ifr_full(rx_ifr_full)
  );
endmodule

// File: tb/tb_j1850_byte_path.sv
`timescale 1ns/1ps
module tb_j1850_byte_path;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_wr = 0, cpu_ifr = 0, cpu_rd = 0, bit_req = 0;
  logic [7:0] cpu_wdata = 0;
  logic rx_sync = 0, rx_bit_vld = 0, rx_bit = 0, rx_in_ifr = 0;
  logic ev_arb = 0, ev_txe = 0, ev_sym = 0, ev_frm = 0, ev_flt = 0, ev_brk = 0, ev_crc = 0;
  logic [7:0] cpu_rdata;
  logic tx_empty, rx_full, rx_ifr_full, tx_pending, tx_pend_ifr;
  logic tx_bit, tx_active, tx_byte_done, tx_underrun, inv_symbol;

  int compared = 0, mismatched = 0;
  bit in_reset = 1'b1;

  always #2 clk = ~clk;

  j1850_byte_path dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_ifr(cpu_ifr),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .tx_empty(tx_empty), .rx_full(rx_full),
    .rx_ifr_full(rx_ifr_full), .tx_pending(tx_pending), .tx_pend_ifr(tx_pend_ifr),
    .bit_req(bit_req), .tx_bit(tx_bit), .tx_active(tx_active),
    .tx_byte_done(tx_byte_done), .tx_underrun(tx_underrun), .inv_symbol(inv_symbol),
    .rx_sync(rx_sync), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit), .rx_in_ifr(rx_in_ifr),
    .ev_arb_lost(ev_arb), .ev_tx_err(ev_txe), .ev_sym_err(ev_sym), .ev_frame_err(ev_frm),
    .ev_bus_fault(ev_flt), .ev_break(ev_brk), .ev_crc_err(ev_crc)
  );

  // behavioural reference model
  logic [7:0] m_hold, m_rdata;
  bit m_full, m_ifr, m_tdre, m_txbit, m_done, m_und, m_inv, m_rdrf, m_rxifr;
  int m_st, m_tail;           // 0 idle, 1 shifting, 2 tail
  bit mq[$];                  // transmit bits still to present
  bit rq[$];                  // received bits of the current byte

  task automatic model_step();
    bit flush, ldok, rend;
    if (rst) begin
      m_hold = 0; m_full = 0; m_ifr = 0; m_tdre = 1; m_txbit = 0; m_done = 0;
      m_und = 0; m_inv = 0; m_st = 0; m_tail = 0; mq.delete(); rq.delete();
      m_rdata = 0; m_rdrf = 0; m_rxifr = 0;
      return;
    end
    m_done = 0; m_und = 0; m_inv = 0;
    flush = ev_arb | ev_txe | ev_sym | ev_frm | ev_flt | ev_brk | (ev_crc & m_full & m_ifr);
    if (flush) begin
      m_full = 0; m_tdre = 1; m_st = 0; m_txbit = 0; mq.delete();
    end else begin
      ldok = bit_req && m_full && (m_st == 0 || (m_st == 1 && mq.size() == 0));
      if (ldok) begin
        mq.delete();
        for (int i = 7; i >= 0; i--) mq.push_back(m_hold[i]);
        m_txbit = mq.pop_front(); m_full = 0; m_tdre = 1; m_st = 1;
      end else if (bit_req && m_st == 1) begin
        if (mq.size() > 0) begin
          m_txbit = mq.pop_front();
          m_done = (mq.size() == 0);
        end else begin
          m_txbit = 1; m_und = 1; m_st = 2; m_tail = 1;
        end
      end else if (bit_req && m_st == 2) begin
        if (m_tail > 0) begin m_txbit = 1; m_tail--; end
        else begin m_txbit = 0; m_inv = 1; m_st = 0; end
      end
      if (cpu_wr) begin m_hold = cpu_wdata; m_full = 1; m_ifr = cpu_ifr; m_tdre = 0; end
    end
    rend = 0;
    if (rx_sync) rq.delete();
    else if (rx_bit_vld) begin
      rq.push_back(rx_bit);
      if (rq.size() == 8) begin
        for (int i = 0; i < 8; i++) m_rdata[7-i] = rq[i];
        rq.delete(); rend = 1;
      end
    end
    if (rend && !rx_in_ifr) m_rdrf = 1; else if (cpu_rd) m_rdrf = 0;
    if (rend && rx_in_ifr) m_rxifr = 1; else if (cpu_rd) m_rxifr = 0;
  endtask

  task automatic chk(string tag, string name, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", in_reset ? "R1" : tag, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R10", "cpu_rdata", cpu_rdata, m_rdata);
    chk("R4", "tx_empty", tx_empty, m_tdre);
    chk("R12", "rx_full", rx_full, m_rdrf);
    chk("R12", "rx_ifr_full", rx_ifr_full, m_rxifr);
    chk("R2", "tx_pending", tx_pending, m_full);
    chk("R2", "tx_pend_ifr", tx_pend_ifr, m_ifr);
    chk("R5", "tx_bit", tx_bit, m_txbit);
    chk("R7", "tx_active", tx_active, m_st != 0);
    chk("R5", "tx_byte_done", tx_byte_done, m_done);
    chk("R7", "tx_underrun", tx_underrun, m_und);
    chk("R7", "inv_symbol", inv_symbol, m_inv);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    cpu_wr = 0; cpu_rd = 0; bit_req = 0; rx_sync = 0; rx_bit_vld = 0;
    ev_arb = 0; ev_txe = 0; ev_sym = 0; ev_frm = 0; ev_flt = 0; ev_brk = 0; ev_crc = 0;
  endtask

  task automatic write(input logic [7:0] d, input logic ifr);
    cpu_wr = 1; cpu_wdata = d; cpu_ifr = ifr; tick();
  endtask

  task automatic collect(input int n, output logic [15:0] bits);
    bits = 0;
    for (int i = 0; i < n; i++) begin bit_req = 1; tick(); bits = {bits[14:0], tx_bit}; end
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic ifr);
    for (int i = 7; i >= 0; i--) begin
      rx_bit_vld = 1; rx_bit = d[i]; rx_in_ifr = ifr; tick();
    end
  endtask

  task automatic direct(string tag, string name, int act, int exp);
    chk(tag, name, act, exp);
  endtask

  initial begin
    logic [15:0] bits;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();       // R1 reset state compared each cycle
    rst = 0;
    in_reset = 0;
    tick();

    // R2/R3: write then replace before first bit
    write(8'hA5, 0);
    direct("R2", "pending_after_write", tx_pending, 1);
    write(8'h3C, 0);
    // R4/R5: first bit shows MSB, empty flag rises with it
    collect(1, bits);
    direct("R4", "empty_after_first_bit", tx_empty, 1);
    write(8'h81, 0);                           // R6: next byte ready before boundary
    collect(7, bits);
    direct("R3", "replaced_byte_low7", bits[6:0], 7'h3C);
    direct("R5", "byte_done_on_bit0", tx_byte_done, 1);
    collect(1, bits);
    direct("R6", "no_gap_active", tx_active, 1);
    direct("R6", "next_msb", tx_bit, 1);
    collect(7, bits);
    // R7: underrun tail of two ones then idle with invalid symbol
    collect(1, bits);
    direct("R7", "underrun_pulse", tx_underrun, 1);
    collect(1, bits);
    direct("R7", "second_tail_one", tx_bit, 1);
    collect(1, bits);
    direct("R7", "inv_symbol_pulse", inv_symbol, 1);
    direct("R7", "idle_after_tail", tx_active, 0);

    // R9: CRC error flushes an IFR byte only
    write(8'h55, 1);
    ev_crc = 1; tick();
    direct("R9", "ifr_flushed", tx_pending, 0);
    write(8'h66, 0);
    ev_crc = 1; tick();
    direct("R9", "plain_kept", tx_pending, 1);
    // R8: each bus event flushes, mid-byte too
    for (int e = 0; e < 6; e++) begin
      write(8'hC3, 0);
      collect(3, bits);
      write(8'h0F, 0);
      case (e)
        0: ev_arb = 1; 1: ev_txe = 1; 2: ev_sym = 1;
        3: ev_frm = 1; 4: ev_flt = 1; default: ev_brk = 1;
      endcase
      tick();
      direct("R8", "flush_pending", tx_pending, 0);
      direct("R8", "flush_idle", tx_active, 0);
    end

    // R10/R11/R12: receive path
    rx_sync = 1; tick();
    rx_byte(8'h5A, 0);
    direct("R10", "rx_byte", cpu_rdata, 8'h5A);
    rx_byte(8'hE7, 1);                         // R11 overwrite without read
    direct("R11", "overwrite", cpu_rdata, 8'hE7);
    cpu_rd = 1; tick();
    direct("R12", "read_clears", rx_full | rx_ifr_full, 0);
    for (int i = 7; i >= 1; i--) begin rx_bit_vld = 1; rx_bit = 1; rx_in_ifr = 0; tick(); end
    rx_bit_vld = 1; rx_bit = 0; cpu_rd = 1; tick();
    direct("R12", "set_beats_read", rx_full, 1);
    rx_bit_vld = 1; rx_bit = 1; tick();
    rx_sync = 1; rx_bit_vld = 1; rx_bit = 1; tick();
    rx_byte(8'h12, 0);
    direct("R10", "sync_realign", cpu_rdata, 8'h12);

    // mixed random traffic against the model
    void'($urandom(17));
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      bit_req    = ($urandom % 3) != 0;
      cpu_wr     = (r < 12);
      cpu_wdata  = 8'($urandom);
      cpu_ifr    = ($urandom % 4) == 0;
      cpu_rd     = ($urandom % 8) == 0;
      rx_sync    = ($urandom % 60) == 0;
      rx_bit_vld = ($urandom % 2) == 0;
      rx_bit     = $urandom % 2;
      rx_in_ifr  = ($urandom % 3) == 0;
      ev_crc     = ($urandom % 40) == 0;
      case ($urandom % 240)
        0: ev_arb = 1; 1: ev_txe = 1; 2: ev_sym = 1;
        3: ev_frm = 1; 4: ev_flt = 1; 5: ev_brk = 1;
        default: ;
      endcase
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule